// File: doc/BRIEF.md
# UART Hardware Flow-Control Unit

This block sits between a UART's receive and transmit FIFOs and the RTS/CTS handshake lines. It paces the serial link in hardware, with no software in the loop. When automatic RTS is on, it compares the receive FIFO fill count against a trigger level chosen by a 2-bit code. It drives the active-low RTS line high (telling the remote end to stop) once the count reaches that level. It drives RTS low again once the FIFO has been read below the level. When automatic RTS is off, RTS follows a software request bit.

When automatic CTS is on, the block passes the active-low CTS input through a two-flop synchronizer. It uses the result to grant or withhold permission for the serializer to start its next character. The decision is taken only while the transmitter reports idle. A character already being shifted out therefore always completes. Only the start of the next character is held back.

Both automatic modes work only while FIFO mode is enabled. With FIFO mode off, the line behaves as a plain software-controlled modem signal, and transmit permission is always granted.

Top module: `uart_flowctl`

## Requirements
- R1: While reset is asserted, `rts_no` is 1 (RTS deasserted) and `tx_permit_o` is 0.
- R2: The trigger code `trig_sel_i` selects the receive threshold as follows: 2'b00 gives 1 character, 2'b01 gives 4, 2'b10 gives 8, and 2'b11 gives 14.
- R3: With automatic RTS active, `rts_no` is 1 one clock after a cycle in which `rx_count_i` is greater than or equal to the selected threshold. This includes a completely full FIFO (count 16).
- R4: With automatic RTS active, `rts_no` is 0 one clock after a cycle in which `rx_count_i` is below the selected threshold.
- R5: When automatic RTS is not active, `rts_no` equals the inverse of `sw_rts_i` from the previous cycle. Here `sw_rts_i` = 1 requests RTS asserted (line low).
- R6: Automatic RTS is active only when both `fifo_en_i` and `auto_rts_en_i` are 1. Automatic CTS is active only when both `fifo_en_i` and `auto_cts_en_i` are 1. With `fifo_en_i` = 0, neither the FIFO count nor CTS has any effect on the outputs.
- R7: With automatic CTS active and `tx_idle_i` = 1, `tx_permit_o` equals the inverse of `cts_ni` three clocks after `cts_ni` changes (two synchronizer flops plus the permit flop). It equals the inverse of the already-synchronized CTS one clock after `tx_idle_i` rises.
- R8: With automatic CTS active, `tx_permit_o` does not change in the clock following a cycle in which `tx_idle_i` = 0. A CTS change during a character is therefore applied only once the transmitter is idle again.
- R9: When automatic CTS is not active, `tx_permit_o` is 1 one clock later, whatever the value of `cts_ni` and `tx_idle_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enabled; a prerequisite for both automatic modes |
| auto_rts_en_i | input | 1 | Automatic RTS enable |
| auto_cts_en_i | input | 1 | Automatic CTS enable |
| sw_rts_i | input | 1 | Software RTS request, 1 = assert RTS |
| rx_count_i | input | 5 | Receive FIFO fill count, 0 to 16 |
| trig_sel_i | input | 2 | Receive trigger level code |
| cts_ni | input | 1 | CTS line, active low, asynchronous |
| tx_idle_i | input | 1 | Serializer idle, between characters |
| rts_no | output | 1 | RTS line, active low |
| tx_permit_o | output | 1 | Serializer may start the next character |

## Verification
Some properties are checked by assertions on every cycle:
- RTS matches the count-versus-threshold comparison while automatic RTS is on.
- RTS mirrors the software bit while automatic RTS is off.
- Transmit permission holds through every busy cycle.
- Permission is forced on when automatic CTS is off.

Other behaviour only the bench scenarios can show:
- The mapping of each trigger code to its actual level.
- The exact three-cycle synchronizer delay on CTS.
- That a CTS change arriving mid-character takes effect at the next idle phase.
- That clearing FIFO mode masks both automatic modes.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
   typedef enum logic [1:0] {
      TRG_ONE  = 2'b00,
      TRG_QTR  = 2'b01,
      TRG_HALF = 2'b10,
      TRG_HIGH = 2'b11
   } trig_sel_e;

   // Map a trigger code onto a character level.
   function automatic int unsigned trig_level(trig_sel_e sel, int unsigned l0, int unsigned l1,
                                              int unsigned l2, int unsigned l3);
      case (sel)
         TRG_ONE:  return l0;
         TRG_QTR:  return l1;
         TRG_HALF: return l2;
         default:  return l3;
      endcase
   endfunction
endpackage

// File: rtl/flowctl_sync.sv
module flowctl_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("flowctl_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/flowctl_rts.sv
module flowctl_rts
   import flowctl_pkg::*;
#(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned LVL0    = 1,
   parameter int unsigned LVL1    = 4,
   parameter int unsigned LVL2    = 8,
   parameter int unsigned LVL3    = 14,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             auto_en_i,
   input  logic             sw_rts_i,
   input  logic [CNT_W-1:0] count_i,
   input  trig_sel_e        sel_i,
   output logic             rts_no
);
   generate
      if (LVL0 == 0 || LVL3 > DEPTH || LVL0 > LVL1 || LVL1 > LVL2 || LVL2 > LVL3) begin : g_bad
         $error("flowctl_rts trigger levels must be ascending and within 1..DEPTH");
      end
   endgenerate

   logic [CNT_W-1:0] thr_lvl;
   logic             rts_nxt;

   always_comb begin
      thr_lvl = CNT_W'(trig_level(sel_i, LVL0, LVL1, LVL2, LVL3));
      if (auto_en_i) rts_nxt = (count_i >= thr_lvl);
      else           rts_nxt = ~sw_rts_i;
   end

   generate
      if (OUT_REG) begin : g_reg
         logic rts_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) rts_q <= 1'b1;
            else         rts_q <= rts_nxt;
         end
         assign rts_no = rts_q;

         a_r3_stop_at_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && $past(auto_en_i) && ($past(count_i) >= $past(thr_lvl))) |-> rts_no);
         a_r4_go_below_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && $past(auto_en_i) && ($past(count_i) < $past(thr_lvl))) |-> !rts_no);
         a_r5_manual_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($past(rst_ni) && !$past(auto_en_i)) |-> (rts_no == !$past(sw_rts_i)));
      end else begin : g_comb
         assign rts_no = rts_nxt;
      end
   endgenerate

   a_r3_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_i <= CNT_W'(DEPTH));
endmodule

// File: rtl/flowctl_txgate.sv
module flowctl_txgate (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic auto_en_i,
   input  logic cts_clear_i,
   input  logic tx_idle_i,
   output logic permit_o
);
   logic permit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        permit_q <= 1'b0;
      else if (!auto_en_i) permit_q <= 1'b1;
      else if (tx_idle_i)  permit_q <= cts_clear_i;
   end

   assign permit_o = permit_q;

   a_r8_hold_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(auto_en_i) && !$past(tx_idle_i)) |-> $stable(permit_o));
   a_r9_free_when_manual: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(auto_en_i)) |-> permit_o);
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
   import flowctl_pkg::*;
#(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LVL0       = 1,
   parameter int unsigned LVL1       = 4,
   parameter int unsigned LVL2       = 8,
   parameter int unsigned LVL3       = 14,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fifo_en_i,
   input  logic             auto_rts_en_i,
   input  logic             auto_cts_en_i,
   input  logic             sw_rts_i,
   input  logic [CNT_W-1:0] rx_count_i,
   input  logic [1:0]       trig_sel_i,
   input  logic             cts_ni,
   input  logic             tx_idle_i,
   output logic             rts_no,
   output logic             tx_permit_o
);
   logic auto_rts, auto_cts, cts_n_sync;

   // R6: both automatic modes need FIFO mode.
   assign auto_rts = fifo_en_i & auto_rts_en_i;
   assign auto_cts = fifo_en_i & auto_cts_en_i;

   flowctl_rts #(
      .DEPTH(DEPTH), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3), .OUT_REG(1'b1)
   ) u_rts (
      .clk_i(clk_i), .rst_ni(rst_ni), .auto_en_i(auto_rts), .sw_rts_i(sw_rts_i),
      .count_i(rx_count_i), .sel_i(trig_sel_e'(trig_sel_i)), .rts_no(rts_no)
   );

   flowctl_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cts_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_ni), .q_o(cts_n_sync)
   );

   flowctl_txgate u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .auto_en_i(auto_cts), .cts_clear_i(~cts_n_sync),
      .tx_idle_i(tx_idle_i), .permit_o(tx_permit_o)
   );

   a_r6_fifo_off_rts_manual: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(fifo_en_i)) |-> (rts_no == !$past(sw_rts_i)));
   a_r6_fifo_off_permit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !$past(fifo_en_i)) |-> tx_permit_o);
endmodule

// File: tb/uart_flowctl_tb_top.sv
module uart_flowctl_tb_top;
   typedef struct {
      int    due;
      bit    chk_rts;
      logic  exp_rts;
      bit    chk_perm;
      logic  exp_perm;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_en = 1'b0, a_rts = 1'b0, a_cts = 1'b0, sw_rts = 1'b0;
   logic [4:0] cnt = '0;
   logic [1:0] sel = '0;
   logic       cts_n = 1'b1, idle = 1'b1;
   logic       rts_n, permit;

   int   cyc = 0, checks = 0, errors = 0;
   bit   done = 1'b0;
   exp_t q[$];

   always #2 clk = ~clk;  // 250 MHz
   always @(posedge clk) cyc <= cyc + 1;

   uart_flowctl dut_i (
      .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .auto_rts_en_i(a_rts),
      .auto_cts_en_i(a_cts), .sw_rts_i(sw_rts), .rx_count_i(cnt), .trig_sel_i(sel),
      .cts_ni(cts_n), .tx_idle_i(idle), .rts_no(rts_n), .tx_permit_o(permit)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Monitor: pops expectations as their cycle comes due.
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due <= cyc) begin
         exp_t it;
         it = q.pop_front();
         if (it.chk_rts) begin
            checks++;
            if (rts_n !== it.exp_rts) begin
               errors++;
               $display("FAIL %s rts_no actual=%b expected=%b", it.tag, rts_n, it.exp_rts);
            end
         end
         if (it.chk_perm) begin
            checks++;
            if (permit !== it.exp_perm) begin
               errors++;
               $display("FAIL %s tx_permit_o actual=%b expected=%b", it.tag, permit, it.exp_perm);
            end
         end
      end
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic expect_out(int lat, bit cr, logic er, bit cp, logic ep, string tag);
      q.push_back('{cyc + lat, cr, er, cp, ep, tag});
      while (q.size() != 0) @(negedge clk);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int lv[4] = '{1, 4, 8, 14};
      #5;
      checks++;  // R1 reset values
      if (rts_n !== 1'b1 || permit !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset rts_no=%b tx_permit_o=%b expected 1/0", rts_n, permit);
      end
      step(); step();
      rst_n = 1'b1;

      // R2/R3/R4: thresholds with automatic RTS
      fifo_en = 1'b1; a_rts = 1'b1;
      for (int s = 0; s < 4; s++) begin
         step(); sel = 2'(s); cnt = 5'(lv[s] - 1);
         expect_out(1, 1, 1'b0, 0, 1'b0, "R2 R4 below level");
         step(); cnt = 5'(lv[s]);
         expect_out(1, 1, 1'b1, 0, 1'b0, "R2 R3 at level");
         step(); cnt = 5'd16;
         expect_out(1, 1, 1'b1, 0, 1'b0, "R3 full fifo");
         step(); cnt = 5'(lv[s] - 1);
         expect_out(1, 1, 1'b0, 0, 1'b0, "R4 drained below");
      end

      // R5: automatic RTS off
      step(); a_rts = 1'b0; cnt = 5'd16; sw_rts = 1'b1;
      expect_out(1, 1, 1'b0, 0, 1'b0, "R5 software assert");
      step(); sw_rts = 1'b0; cnt = 5'd0;
      expect_out(1, 1, 1'b1, 0, 1'b0, "R5 software deassert");

      // R6: FIFO mode off masks both modes
      step(); fifo_en = 1'b0; a_rts = 1'b1; a_cts = 1'b1; sw_rts = 1'b1;
      cnt = 5'd16; cts_n = 1'b1; idle = 1'b1;
      expect_out(3, 1, 1'b0, 1, 1'b1, "R6 fifo off");

      // R7: automatic CTS while idle
      step(); fifo_en = 1'b1; a_rts = 1'b0;
      expect_out(1, 0, 1'b0, 1, 1'b0, "R7 cts high blocks");
      step(); cts_n = 1'b0;
      expect_out(3, 0, 1'b0, 1, 1'b1, "R7 cts low grants");

      // R8: CTS changes mid-character
      step(); idle = 1'b0; cts_n = 1'b1;
      expect_out(3, 0, 1'b0, 1, 1'b1, "R8 finish current char");
      step(); idle = 1'b1;
      expect_out(1, 0, 1'b0, 1, 1'b0, "R7 blocked at boundary");
      step(); idle = 1'b0; cts_n = 1'b0;
      expect_out(3, 0, 1'b0, 1, 1'b0, "R8 no start while busy");
      step(); idle = 1'b1;
      expect_out(1, 0, 1'b0, 1, 1'b1, "R7 resume at boundary");

      // R9: automatic CTS off
      step(); cts_n = 1'b1;
      expect_out(3, 0, 1'b0, 1, 1'b0, "R7 blocked again");
      step(); a_cts = 1'b0; idle = 1'b0;
      expect_out(1, 0, 1'b0, 1, 1'b1, "R9 manual permit");

      step(); step();
      finish_run();
   end
endmodule